// File: doc/BRIEF.md
# Decode-Stage Stall Unit with Early Branch Resolution

This block decides, every cycle, whether the instruction sitting in the decode stage of a five-stage pipeline can proceed. The pipeline compares branch operands in decode, so a branch needs its source values one stage earlier than an ALU instruction does. Forwarding paths outside this block supply most results in time. This unit finds the cases where they cannot.

When a stall is needed, the unit drops the program-counter write enable and the fetch/decode register write enable. The same instruction is then decoded again on the next cycle, and the following instruction is fetched again. At the same time the unit raises a bubble enable, which makes the decode/execute register load all-zero control bits, so the stages further down do no work for that slot.

The block is purely combinational. It looks at the two source register numbers in decode, a flag saying that the decoded instruction is a branch, and the destination, load and register-write information held in the decode/execute and execute/memory stages. When a branch follows a load directly, the stall condition is evaluated again on the second cycle after the load has advanced one stage. This gives a two-cycle hold without any internal state.

Top module: `decode_stall_unit`

## Requirements
- R1: When the decode/execute stage holds a load (`dx_is_load`=1) whose destination equals `id_src_a` or `id_src_b`, the unit stalls: `pc_write`=0, `ifid_write`=0, `dx_bubble`=1. This applies whether or not the decoded instruction is a branch.
- R2: The three outputs always agree. `pc_write` equals `ifid_write`, and `dx_bubble` is the inverse of both.
- R3: When `id_is_branch`=1 and the decode/execute stage holds a non-load instruction with `dx_writes_reg`=1 whose destination equals either branch source, the unit stalls.
- R4: When `id_is_branch`=1 and the execute/memory stage holds a load (`xm_is_load`=1) whose destination equals either branch source, the unit stalls.
- R5: When a branch directly follows a load that writes one of its sources, the stall lasts exactly two cycles. In the first cycle the load is in decode/execute. In the second cycle the load is in execute/memory and decode/execute holds the bubble. On the third cycle, with the load gone, the branch proceeds.
- R6: A non-load result in execute/memory never stalls, branch or not. A non-load ALU result in decode/execute does not stall a non-branch instruction. A load in execute/memory does not stall a non-branch instruction.
- R7: A destination register number of 0 never causes a stall in any stage (parameter `ZERO_REG_FIXED`=1, the default).
- R8: With no stall condition present, `pc_write`=1, `ifid_write`=1 and `dx_bubble`=0.
- R9: A non-load instruction in decode/execute with `dx_writes_reg`=0 does not stall a branch, even when its destination field matches a branch source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_ADDR_W | First source register number of the decoded instruction |
| id_src_b | input | REG_ADDR_W | Second source register number of the decoded instruction |
| id_is_branch | input | 1 | Decoded instruction compares registers in decode |
| dx_is_load | input | 1 | Decode/execute stage holds a memory read |
| dx_writes_reg | input | 1 | Decode/execute stage will write a register |
| dx_dest | input | REG_ADDR_W | Destination register of the decode/execute instruction |
| xm_is_load | input | 1 | Execute/memory stage holds a memory read |
| xm_writes_reg | input | 1 | Execute/memory stage will write a register |
| xm_dest | input | REG_ADDR_W | Destination register of the execute/memory instruction |
| pc_write | output | 1 | Program counter may advance |
| ifid_write | output | 1 | Fetch/decode register may load |
| dx_bubble | output | 1 | Load zero control bits into decode/execute |

## Verification
Two detectors can fire in the same cycle: the load-use check, which covers the decode/execute stage, and the branch check, which covers both stages. An example is a branch whose first source matches a load in decode/execute while its second source matches a load in execute/memory. The bench reaches every such overlap by sweeping all input combinations of a two-bit register-number configuration. It judges each combination against an expected stall computed arithmetically from the requirement rules, with the firing rule named in any failure. A replayed load-then-branch sequence shows that the overlap produces one hold per cycle across both cycles of the double stall.

// File: rtl/hz_pkg.sv
package hz_pkg;
   // Which rule asserted the hold (used for naming only)
   typedef enum logic [1:0] {
      HZ_NONE      = 2'd0,
      HZ_LOAD_USE  = 2'd1,
      HZ_BR_DX     = 2'd2,
      HZ_BR_XM     = 2'd3
   } hz_cause_e;

   // Per-stage producer description
   typedef struct packed {
      logic is_load;
      logic writes_reg;
   } hz_prod_t;
endpackage

// File: rtl/hz_reg_hit.sv
module hz_reg_hit #(
   parameter int REG_ADDR_W     = 5,
   parameter bit ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_ADDR_W-1:0] dest,
   input  logic [REG_ADDR_W-1:0] src_a,
   input  logic [REG_ADDR_W-1:0] src_b,
   output logic                  hit
);
   localparam logic [REG_ADDR_W-1:0] ZERO_IDX = '0;

   logic match_any;
   assign match_any = (dest == src_a) || (dest == src_b);

   generate
      if (ZERO_REG_FIXED) begin : g_zero_fixed
         // register 0 is constant, writes to it are never real producers
         assign hit = match_any && (dest != ZERO_IDX);
      end else begin : g_zero_plain
         assign hit = match_any;
      end
   endgenerate
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use (
   input  hz_pkg::hz_prod_t dx_prod,
   input  logic             dx_hit,
   output logic             stall
);
   // a load result reaches execute only after its memory cycle
   assign stall = dx_prod.is_load && dx_hit;
endmodule

// File: rtl/hz_branch_stall.sv
module hz_branch_stall #(
   parameter bit EARLY_BRANCH = 1'b1
) (
   input  logic             is_branch,
   input  hz_pkg::hz_prod_t dx_prod,
   input  logic             dx_hit,
   input  hz_pkg::hz_prod_t xm_prod,
   input  logic             xm_hit,
   output logic             stall_dx,
   output logic             stall_xm
);
   generate
      if (EARLY_BRANCH) begin : g_early
         // ALU result still in execute: needed by the compare one cycle early
         assign stall_dx = is_branch && dx_prod.writes_reg && !dx_prod.is_load && dx_hit;
         // load data still in memory access: not available to decode yet
         assign stall_xm = is_branch && xm_prod.is_load && xm_hit;
      end else begin : g_late
         assign stall_dx = 1'b0;
         assign stall_xm = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/decode_stall_unit.sv
module decode_stall_unit #(
   parameter int REG_ADDR_W     = 5,
   parameter bit ZERO_REG_FIXED = 1'b1,
   parameter bit EARLY_BRANCH   = 1'b1
) (
   input  logic [REG_ADDR_W-1:0] id_src_a,
   input  logic [REG_ADDR_W-1:0] id_src_b,
   input  logic                  id_is_branch,
   input  logic                  dx_is_load,
   input  logic                  dx_writes_reg,
   input  logic [REG_ADDR_W-1:0] dx_dest,
   input  logic                  xm_is_load,
   input  logic                  xm_writes_reg,
   input  logic [REG_ADDR_W-1:0] xm_dest,
   output logic                  pc_write,
   output logic                  ifid_write,
   output logic                  dx_bubble
);
   import hz_pkg::*;

   localparam int MIN_W   = 2;
   localparam int MAX_W   = 8;
   localparam int N_STAGE = 2;

   generate
      if (REG_ADDR_W < MIN_W || REG_ADDR_W > MAX_W) begin : g_bad_width
         $error("decode_stall_unit: REG_ADDR_W out of supported range");
      end
   endgenerate

   hz_prod_t                  prod [N_STAGE];
   logic [REG_ADDR_W-1:0]     dest [N_STAGE];
   logic [N_STAGE-1:0]        hit;

   assign prod[0] = '{is_load: dx_is_load, writes_reg: dx_writes_reg};
   assign prod[1] = '{is_load: xm_is_load, writes_reg: xm_writes_reg};
   assign dest[0] = dx_dest;
   assign dest[1] = xm_dest;

   for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
      hz_reg_hit #(
         .REG_ADDR_W    (REG_ADDR_W),
         .ZERO_REG_FIXED(ZERO_REG_FIXED)
      ) u_hit (
         .dest (dest[s]),
         .src_a(id_src_a),
         .src_b(id_src_b),
         .hit  (hit[s])
      );
   end

   logic lu_stall, br_dx_stall, br_xm_stall;

   hz_load_use u_lu (
      .dx_prod(prod[0]),
      .dx_hit (hit[0]),
      .stall  (lu_stall)
   );

   hz_branch_stall #(.EARLY_BRANCH(EARLY_BRANCH)) u_br (
      .is_branch(id_is_branch),
      .dx_prod  (prod[0]),
      .dx_hit   (hit[0]),
      .xm_prod  (prod[1]),
      .xm_hit   (hit[1]),
      .stall_dx (br_dx_stall),
      .stall_xm (br_xm_stall)
   );

   hz_cause_e cause;
   always_comb begin
      if (lu_stall)         cause = HZ_LOAD_USE;
      else if (br_dx_stall) cause = HZ_BR_DX;
      else if (br_xm_stall) cause = HZ_BR_XM;
      else                  cause = HZ_NONE;
   end

   logic hold;
   assign hold       = (cause != HZ_NONE);
   assign pc_write   = !hold;
   assign ifid_write = !hold;
   assign dx_bubble  = hold;
endmodule

// File: rtl/decode_stall_unit_chk.sv
module decode_stall_unit_chk #(
   parameter int REG_ADDR_W = 5
) (
   input logic [REG_ADDR_W-1:0] id_src_a,
   input logic [REG_ADDR_W-1:0] id_src_b,
   input logic                  id_is_branch,
   input logic                  dx_is_load,
   input logic                  dx_writes_reg,
   input logic [REG_ADDR_W-1:0] dx_dest,
   input logic                  xm_is_load,
   input logic [REG_ADDR_W-1:0] xm_dest,
   input logic                  pc_write,
   input logic                  ifid_write,
   input logic                  dx_bubble
);
   logic dx_zero, xm_zero;
   assign dx_zero = (dx_dest == '0);
   assign xm_zero = (xm_dest == '0);

   always_comb begin
      // R2: hold and bubble outputs never disagree
      a_r2_outputs_agree: assert ((pc_write == ifid_write) && (dx_bubble == !pc_write))
         else $error("R2 outputs disagree");
      // R1: load in decode/execute feeding decode source must hold
      if (dx_is_load && !dx_zero && ((dx_dest == id_src_a) || (dx_dest == id_src_b)))
         a_r1_load_use_holds: assert (dx_bubble && !pc_write)
            else $error("R1 load-use not held");
      // R4: branch source pending from load in execute/memory must hold
      if (id_is_branch && xm_is_load && !xm_zero && ((xm_dest == id_src_a) || (xm_dest == id_src_b)))
         a_r4_branch_xm_load: assert (dx_bubble)
            else $error("R4 branch after load not held");
      // R7: only zero destinations present means no hold
      if (dx_zero && xm_zero)
         a_r7_zero_dest_free: assert (pc_write && !dx_bubble)
            else $error("R7 zero destination stalled");
      // R6: non-branch with no load in decode/execute never holds
      if (!id_is_branch && !dx_is_load)
         a_r6_forwardable_free: assert (pc_write)
            else $error("R6 forwardable case stalled");
   end
endmodule

bind decode_stall_unit decode_stall_unit_chk #(.REG_ADDR_W(REG_ADDR_W)) u_chk (
   .id_src_a     (id_src_a),
   .id_src_b     (id_src_b),
   .id_is_branch (id_is_branch),
   .dx_is_load   (dx_is_load),
   .dx_writes_reg(dx_writes_reg),
   .dx_dest      (dx_dest),
   .xm_is_load   (xm_is_load),
   .xm_dest      (xm_dest),
   .pc_write     (pc_write),
   .ifid_write   (ifid_write),
   .dx_bubble    (dx_bubble)
);

// File: tb/decode_stall_unit_tb_top.sv
module decode_stall_unit_tb_top;
   localparam int W = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;   // 125 MHz

   logic [W-1:0] src_a, src_b, dxd, xmd;
   logic br, dxl, dxw, xml, xmw;
   logic pcw, ifw, bub;

   decode_stall_unit #(.REG_ADDR_W(W)) dut_i (
      .id_src_a(src_a), .id_src_b(src_b), .id_is_branch(br),
      .dx_is_load(dxl), .dx_writes_reg(dxw), .dx_dest(dxd),
      .xm_is_load(xml), .xm_writes_reg(xmw), .xm_dest(xmd),
      .pc_write(pcw), .ifid_write(ifw), .dx_bubble(bub)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic isb,
                        input logic l1, input logic w1, input logic [W-1:0] d1,
                        input logic l2, input logic w2, input logic [W-1:0] d2);
      @(negedge clk);
      src_a = a; src_b = b; br = isb;
      dxl = l1; dxw = w1; dxd = d1;
      xml = l2; xmw = w2; xmd = d2;
      #2;
   endtask

   task automatic check_hold(input string req, input logic exp_hold);
      n_chk++;
      if (pcw !== !exp_hold || ifw !== !exp_hold || bub !== exp_hold) begin
         n_bad++;
         $display("FAIL %s: pc_write=%b ifid_write=%b bubble=%b expected hold=%b",
                  req, pcw, ifw, bub, exp_hold);
      end
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      src_a = '0; src_b = '0; br = 0; dxl = 0; dxw = 0; dxd = '0;
      xml = 0; xmw = 0; xmd = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // R8: idle after reset, no hold
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
      check_hold("R8 idle", 1'b0);

      // R1: load in dx, consumer uses it as src_b (non-branch)
      drive(1, 2, 0, 1, 1, 2, 0, 0, 0);
      check_hold("R1 load-use src_b", 1'b1);
      // R3: branch after ALU writing src_a
      drive(3, 1, 1, 0, 1, 3, 0, 0, 0);
      check_hold("R3 branch after ALU", 1'b1);
      // R9: ALU in dx not writing
      drive(3, 1, 1, 0, 0, 3, 0, 0, 0);
      check_hold("R9 non-writing dx", 1'b0);
      // R6: ALU result in xm, branch: forwarded
      drive(2, 3, 1, 0, 0, 0, 0, 1, 3);
      check_hold("R6 xm ALU branch", 1'b0);
      // R4: load two earlier, branch
      drive(2, 3, 1, 0, 0, 0, 1, 1, 3);
      check_hold("R4 xm load branch", 1'b1);
      // R7: zero destination load in dx
      drive(0, 0, 1, 1, 1, 0, 1, 1, 0);
      check_hold("R7 zero dest", 1'b0);

      // R5: load r1 then branch on r1: hold 2 cycles then proceed
      drive(1, 2, 1, 1, 1, 1, 0, 0, 0);
      check_hold("R5 cycle1", 1'b1);
      drive(1, 2, 1, 0, 0, 0, 1, 1, 1);   // bubble in dx, load in xm
      check_hold("R5 cycle2", 1'b1);
      drive(1, 2, 1, 0, 0, 0, 0, 0, 0);   // load retired
      check_hold("R5 cycle3", 1'b0);
      // R5 contrast: ALU consumer of the same load proceeds on cycle 2
      drive(1, 2, 0, 0, 0, 0, 1, 1, 1);
      check_hold("R5 alu consumer cycle2", 1'b0);

      // Exhaustive sweep (R1 R2 R3 R4 R6 R7 R8 R9)
      for (int v = 0; v < (1 << (4*W + 5)); v++) begin
         logic [W-1:0] a, b, d1, d2;
         logic isb, l1, w1, l2, w2, h1, h2, e_lu, e_b1, e_b2, exp_h;
         string why;
         a   = v[W-1:0];
         b   = v[2*W-1:W];
         d1  = v[3*W-1:2*W];
         d2  = v[4*W-1:3*W];
         isb = v[4*W];
         l1  = v[4*W+1];
         w1  = v[4*W+2];
         l2  = v[4*W+3];
         w2  = v[4*W+4];
         h1 = (d1 != 0) && (d1 == a || d1 == b);
         h2 = (d2 != 0) && (d2 == a || d2 == b);
         e_lu = l1 && h1;
         e_b1 = isb && w1 && !l1 && h1;
         e_b2 = isb && l2 && h2;
         exp_h = e_lu | e_b1 | e_b2;
         if (e_lu)      why = "R1 sweep";
         else if (e_b1) why = "R3 sweep";
         else if (e_b2) why = "R4 sweep";
         else if (d1 == 0 && d2 == 0) why = "R7 sweep";
         else           why = "R6/R9 sweep";
         drive(a, b, isb, l1, w1, d1, l2, w2, d2);
         check_hold(why, exp_h);
         n_chk++;
         if (pcw !== ifw || bub !== !pcw) begin
            n_bad++;
            $display("FAIL R2: pc_write=%b ifid_write=%b bubble=%b expected agreement",
                     pcw, ifw, bub);
         end
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule